// File: doc/BRIEF.md
# Receive-Only Serial Word Port with Clock-Domain Crossing

This block is a serial target that only listens. An external master drives a serial clock, an active-low select and a data line. The serial clock runs on its own and has no phase relation to the system clock. Bits are shifted in on the serial clock's own edges. Each completed word is parked in a holding register that does not change again until the next word completes. A toggle flag announces the word. The flag crosses into the system clock domain through a chain of flip-flops. When its change is seen, the system side copies the parked word.

On the system side, words go into a small queue, so a polling processor can collect them at its own pace. It only has to drain the queue fast enough to keep it from filling. A mode input turns the queue into a latest-value register instead. In that mode every new word replaces whatever was held. The processor sees a data word, a valid flag and a sticky overflow flag. A read strobe pops the oldest entry, and a clear strobe resets the overflow flag.

Top module: `spi_sink_port`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `rd_valid` and `overflow` are 0.
- R2: A word is 16 bits, sampled from `mosi` on rising `sclk` while `cs_n` is low, with the first bit taken as bit 15 (MSB first).
- R3: In queue mode (`latest_mode`=0), words are read out in the order they were received.
- R4: Raising `cs_n` before the 16th bit discards the partial word. The next transfer starts again at bit 15.
- R5: `rd_valid` is high exactly when at least one word is held. A `rd_stb` pulse while `rd_valid` is high removes the oldest word. A `rd_stb` pulse while nothing is held has no effect.
- R6: The queue holds 8 words. In queue mode, a word that arrives while 8 words are held is dropped, and the 8 stored words stay intact.
- R7: A dropped word sets `overflow`. It stays set until a one-cycle `ovf_clr` pulse clears it. If a drop and a clear happen in the same cycle, the set wins.
- R8: In latest mode (`latest_mode`=1), each new word replaces all held content, leaving exactly that one word. `overflow` is never set in this mode.
- R9: A completed word appears on `rd_valid`/`rd_data` no later than 5 system clock cycles after the final rising `sclk` edge of that word. This holds only when the word arrives at an empty queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (system domain) |
| sclk | input | 1 | Serial clock from the external master |
| cs_n | input | 1 | Active-low select; high aborts any partial word |
| mosi | input | 1 | Serial data from the master |
| latest_mode | input | 1 | 1: keep only the newest word; 0: queue words |
| rd_stb | input | 1 | Pop the oldest held word |
| ovf_clr | input | 1 | Clear the sticky overflow flag |
| rd_data | output | 16 | Oldest held word (newest in latest mode) |
| rd_valid | output | 1 | At least one word is held |
| overflow | output | 1 | Sticky flag: a word was dropped |

## Verification
The bench builds the block with its defaults: 16-bit words, a queue 8 deep and two synchronizer stages. With only 8 entries, a run of nine back-to-back words is enough to reach the full-queue drop. The random phase then wanders repeatedly across the full and empty boundaries. A serial clock of 10 MHz against a 50 MHz system clock keeps the two edges drifting relative to each other. This exercises the handover at many phase offsets while the 5-cycle delivery bound is checked.

// File: rtl/spi_sink_pkg.sv
package spi_sink_pkg;
  localparam int unsigned WORD_W      = 16;
  localparam int unsigned QUEUE_DEPTH = 8;
  localparam int unsigned SYNC_STAGES = 2;

  function automatic int unsigned ptr_w(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/spi_sink_shift.sv
// Serial-domain side: shift register, bit counter, frozen holding word, toggle flag.
module spi_sink_shift #(
  parameter int unsigned W = 16
) (
  input  logic         sclk,
  input  logic         cs_n,
  input  logic         mosi,
  output logic [W-1:0] hold_word,
  output logic         word_tog
);
  localparam int unsigned CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [CNT_W-1:0] bit_cnt;
  logic [W-2:0]     shreg;
  logic             done;

  assign done = (bit_cnt == LAST);

  // Select high clears the partial state at once.
  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (done) begin
      bit_cnt <= '0;
    end else begin
      bit_cnt <= bit_cnt + 1'b1;
      shreg   <= {shreg[W-3:0], mosi};
    end
  end

  // Frozen copy: only rewritten when the following word completes.
  always_ff @(posedge sclk) begin
    if (!cs_n && done) hold_word <= {shreg, mosi};
  end

  always_ff @(posedge sclk) begin
    if (!cs_n && done) word_tog <= ~word_tog;
  end
endmodule

// File: rtl/spi_sink_xfer.sv
// System-domain side of the handover: synchronize the toggle, detect its change,
// sample the frozen word.
module spi_sink_xfer #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] hold_word,
  input  logic         word_tog,
  output logic         word_stb,
  output logic [W-1:0] word_data
);
  logic [STAGES-1:0] sync_q;
  logic              seen_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) sync_q[0] <= word_tog;
    end else begin : g_many
      always_ff @(posedge clk) sync_q <= {sync_q[STAGES-2:0], word_tog};
    end
  endgenerate

  // During reset the edge detector tracks the chain, so no event is invented.
  always_ff @(posedge clk) seen_q <= sync_q[STAGES-1];

  assign word_stb  = !rst && (sync_q[STAGES-1] != seen_q);
  assign word_data = hold_word;
endmodule

// File: rtl/spi_sink_queue.sv
// Word queue with a latest-value mode and a sticky drop flag.
module spi_sink_queue #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       latest,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  input  logic                       ovf_clr,
  output logic [W-1:0]               rdata,
  output logic                       valid,
  output logic                       overflow,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int unsigned AW = spi_sink_pkg::ptr_w(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, empty, do_pop, accept, drop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (count == FULL_CNT);
  assign empty  = (count == '0);
  assign do_pop = pop && !empty;
  assign accept = push && (latest || !full || do_pop);
  assign drop   = push && !latest && full && !do_pop;

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (latest && push) begin
      rd_ptr <= wr_ptr;
      wr_ptr <= bump(wr_ptr);
      count  <= CW'(1);
    end else begin
      if (accept) wr_ptr <= bump(wr_ptr);
      if (do_pop) rd_ptr <= bump(rd_ptr);
      if (accept && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !accept) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          overflow <= 1'b0;
    else if (drop)    overflow <= 1'b1;
    else if (ovf_clr) overflow <= 1'b0;
  end

  assign rdata = mem[rd_ptr];
  assign valid = !empty;
endmodule

// File: rtl/spi_sink_port.sv
module spi_sink_port #(
  parameter int unsigned WORD_W      = spi_sink_pkg::WORD_W,
  parameter int unsigned DEPTH       = spi_sink_pkg::QUEUE_DEPTH,
  parameter int unsigned SYNC_STAGES = spi_sink_pkg::SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  input  logic              latest_mode,
  input  logic              rd_stb,
  input  logic              ovf_clr,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              overflow
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] hold_word, word_data;
  logic              word_tog, word_stb;
  logic [CW-1:0]     fifo_count;

  spi_sink_shift #(.W(WORD_W)) u_shift (
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .hold_word(hold_word), .word_tog(word_tog)
  );

  spi_sink_xfer #(.W(WORD_W), .STAGES(SYNC_STAGES)) u_xfer (
    .clk(clk), .rst(rst), .hold_word(hold_word), .word_tog(word_tog),
    .word_stb(word_stb), .word_data(word_data)
  );

  spi_sink_queue #(.W(WORD_W), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst(rst), .latest(latest_mode), .push(word_stb),
    .wdata(word_data), .pop(rd_stb), .ovf_clr(ovf_clr),
    .rdata(rd_data), .valid(rd_valid), .overflow(overflow), .count(fifo_count)
  );
endmodule

// File: rtl/spi_sink_port_chk.sv
module spi_sink_port_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          latest_mode,
  input logic          rd_stb,
  input logic          ovf_clr,
  input logic          rd_valid,
  input logic          overflow,
  input logic          word_stb,
  input logic [CW-1:0] fifo_count
);
  p_reset_r1: assert property (@(posedge clk) rst |=> (!rd_valid && !overflow));

  p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= CW'(DEPTH));

  p_drop_keeps_r6: assert property (@(posedge clk) disable iff (rst)
    (!latest_mode && word_stb && fifo_count == CW'(DEPTH) && !rd_stb)
      |=> (overflow && fifo_count == CW'(DEPTH)));

  p_pop_one_r5: assert property (@(posedge clk) disable iff (rst)
    (!latest_mode && !word_stb && rd_stb && rd_valid)
      |=> (fifo_count == $past(fifo_count) - 1'b1));

  p_empty_pop_r5: assert property (@(posedge clk) disable iff (rst)
    (!word_stb && !rd_valid) |=> !rd_valid);

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (overflow && !ovf_clr) |=> overflow);

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (ovf_clr && !word_stb) |=> !overflow);

  p_latest_one_r8: assert property (@(posedge clk) disable iff (rst)
    (latest_mode && word_stb) |=> (fifo_count == CW'(1)));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (latest_mode && !overflow) |=> !overflow);
endmodule

bind spi_sink_port spi_sink_port_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .latest_mode(latest_mode), .rd_stb(rd_stb),
  .ovf_clr(ovf_clr), .rd_valid(rd_valid), .overflow(overflow),
  .word_stb(word_stb), .fifo_count(fifo_count)
);

// File: tb/spi_sink_port_bench.sv
`timescale 1ns/1ps
module spi_sink_port_bench;
  localparam int DEPTH = 8;

  logic clk = 0, rst = 1, sclk = 0, cs_n = 1, mosi = 0;
  logic latest_mode = 0, rd_stb = 0, ovf_clr = 0;
  logic [15:0] rd_data;
  logic rd_valid, overflow;

  int checks = 0, errors = 0;
  logic lat_valid;
  logic [15:0] lat_data;
  logic [15:0] mq[$];
  logic m_ovf = 0;
  logic [15:0] last_w;

  always #10 clk = ~clk;

  spi_sink_port u_spi_sink_port (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .latest_mode(latest_mode), .rd_stb(rd_stb), .ovf_clr(ovf_clr),
    .rd_data(rd_data), .rd_valid(rd_valid), .overflow(overflow)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic m_full();
    return mq.size() >= DEPTH;
  endfunction

  // Full word, MSB first; samples the outputs 5 system cycles after the last rise.
  task automatic send_word(input logic [15:0] w);
    cs_n = 0; #40;
    for (int i = 15; i >= 0; i--) begin
      mosi = w[i]; #50; sclk = 1;
      if (i != 0) begin #50; sclk = 0; end
    end
    repeat (5) @(negedge clk);
    lat_valid = rd_valid; lat_data = rd_data;
    sclk = 0; #30; cs_n = 1; #100;
  endtask

  task automatic send_partial(input logic [15:0] w, input int n);
    cs_n = 0; #40;
    for (int i = 15; i > 15 - n; i--) begin
      mosi = w[i]; #50; sclk = 1; #50; sclk = 0;
    end
    #30; cs_n = 1; #100;
  endtask

  // Queue-mode send with model update.
  task automatic send_model(input logic [15:0] w);
    send_word(w);
    if (m_full()) m_ovf = 1; else mq.push_back(w);
  endtask

  task automatic pop_check(input string tag);
    @(negedge clk);
    chk({tag, " valid"}, rd_valid, 1);
    if (mq.size() != 0) chk({tag, " data"}, rd_data, mq[0]);
    rd_stb = 1; @(negedge clk); rd_stb = 0;
    if (mq.size() != 0) void'(mq.pop_front());
  endtask

  task automatic clear_ovf();
    @(negedge clk); ovf_clr = 1; @(negedge clk); ovf_clr = 0; m_ovf = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", rd_valid, 0);
    chk("R1 overflow in reset", overflow, 0);
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk("R1 valid after reset", rd_valid, 0);
    chk("R1 overflow after reset", overflow, 0);

    // R2, R9: first word into empty queue, bit order and latency
    send_model(16'hA5C3);
    chk("R9 valid within 5 cycles", lat_valid, 1);
    chk("R2 msb-first word", lat_data, 16'hA5C3);
    send_model(16'h8001);
    send_model(16'h1234);
    pop_check("R3 order 1");
    pop_check("R3 order 2");
    pop_check("R3 order 3");
    @(negedge clk);
    chk("R5 valid low when empty", rd_valid, 0);
    // R5: pop on empty has no effect
    @(negedge clk); rd_stb = 1; @(negedge clk); rd_stb = 0;
    send_model(16'h0F0F);
    chk("R5 empty pop ignored, next word", lat_data, 16'h0F0F);
    pop_check("R5 single pop");
    @(negedge clk);
    chk("R5 valid after single pop", rd_valid, 0);

    // R4: aborted partial word
    send_partial(16'hFFFF, 5);
    @(negedge clk);
    chk("R4 partial not delivered", rd_valid, 0);
    send_model(16'h00FF);
    chk("R4 realigned word", lat_data, 16'h00FF);
    pop_check("R4 pop");

    // R6, R7: fill and drop
    for (int k = 0; k < DEPTH + 1; k++) send_model(16'h1000 + 16'(k * 17));
    @(negedge clk);
    chk("R7 overflow set on drop", overflow, 1);
    for (int k = 0; k < DEPTH; k++) pop_check("R6 stored words intact");
    @(negedge clk);
    chk("R6 ninth word dropped", rd_valid, 0);
    chk("R7 overflow sticky", overflow, 1);
    clear_ovf();
    chk("R7 overflow cleared", overflow, 0);

    // R8: latest mode
    @(negedge clk); latest_mode = 1;
    for (int k = 0; k < 10; k++) begin
      last_w = 16'($urandom);
      send_word(last_w);
    end
    @(negedge clk);
    chk("R8 newest word kept", rd_data, last_w);
    chk("R8 no overflow", overflow, 0);
    rd_stb = 1; @(negedge clk); rd_stb = 0;
    @(negedge clk);
    chk("R8 only one word held", rd_valid, 0);
    latest_mode = 0;

    // Random queue-mode traffic
    for (int it = 0; it < 60; it++) begin
      int unsigned r;
      r = $urandom % 8;
      if (r < 4) send_model(16'($urandom));
      else if (r < 7) begin
        if (mq.size() != 0) pop_check("R3 random order");
        else begin
          @(negedge clk); rd_stb = 1; @(negedge clk); rd_stb = 0;
          @(negedge clk); chk("R5 random empty pop", rd_valid, 0);
        end
      end else clear_ovf();
      @(negedge clk);
      chk("R7 random overflow", overflow, m_ovf);
      chk("R5 random valid", rd_valid, mq.size() != 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule